// File: doc/BRIEF.md
# GPIO Pin Register Bank

This block holds the four byte-wide registers that sit behind a serial-bus port expander and drive eight bidirectional pins. A serial front end (not part of this block) decodes bus transactions into single-cycle register accesses. Each access is a strobe, a write flag, a command value and a write byte. The command value picks one register: a read-only view of the pins, the stored output levels, a per-pin inversion mask, or a per-pin direction mask.

Pin levels come in through a two-flop synchronizer and are XOR-ed with the inversion mask. The result is captured into the read-data register at the moment the read is accepted, so one returned byte is always a coherent snapshot. The direction mask turns each pin's push-pull driver on or off. The driven value comes from the output register and is forced low on pins that are inputs. Pin-side outputs are registered.

Top module: `gpio_regbank`

## Requirements
- R1: After reset the output register reads 0xFF, the inversion mask reads 0x00 and the direction mask reads 0xFF, so `pin_oe` is 0x00 and every pin is an input.
- R2: Writing command 1, 2 or 3 stores the byte in the output register, the inversion mask or the direction mask respectively, and a later read of the same command returns it.
- R3: Command 0 (the pin view) is read-only: a write to it changes no register, no pin output and no later read value.
- R4: A direction bit of 0 drives the pin (`pin_oe` bit = 1, `pin_do` bit = output register bit). A direction bit of 1 turns the driver off. `pin_oe` and `pin_do` follow a write two clock edges after the write is accepted.
- R5: Output register bits have no effect on input pins: where the direction bit is 1, `pin_do` is 0 whatever the output register holds.
- R6: Each inversion mask bit set to 1 inverts that pin's value in a command-0 read; a bit of 0 passes the value unchanged.
- R7: A command-0 read returns the level of every pin, including pins that the block itself drives as outputs.
- R8: A command-1 read returns the stored output register, not the pin level.
- R9: With a command above 3 (the upper command bits nonzero), a read returns 0x00 and a write is ignored.
- R10: `rd_valid` is high for exactly the one cycle after a read is accepted and stays low after writes and idle cycles; `rd_data` holds the value during that cycle.
- R11: A pin change is seen by a command-0 read accepted two or more edges after the edge at which the new level is first sampled. A read accepted at that first edge still returns the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_cmd | input | CMD_W (3) | Register select command |
| acc_wdata | input | WIDTH (8) | Write byte |
| rd_data | output | WIDTH (8) | Read result, registered |
| rd_valid | output | 1 | Read result valid |
| pin_in | input | WIDTH (8) | Pin levels from the pads |
| pin_oe | output | WIDTH (8) | Per-pin driver enable |
| pin_do | output | WIDTH (8) | Per-pin driven value |

## Verification
The pins are modelled with pull-ups and an external driver that can be switched per bit. This lets a command-0 read tell apart the block's own driven level, an external level and the pull-up level. Mixed direction masks such as 0xC3 show that the output register only reaches driven pins and that the pin view follows driven pins too. An all-input mask with external low levels and a stored 0xFF separates a read of the stored flop from a read of the pin. Two inversion masks (0x0F and 0xF0) against the same pin pattern show per-bit inversion. Writes to command 0 and to commands above 3 are followed by read-back of every register and the pins. A pin change followed by reads one and two edges later pins down the synchronizer latency.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
  typedef enum logic [1:0] {
    SEL_PINS = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_INV  = 2'd2,
    SEL_DIR  = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e to_sel(input logic [1:0] low_bits);
    return reg_sel_e'(low_bits);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '1;
    else     stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '1;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_regbank_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] inv_q,
  output logic [WIDTH-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '1;
      inv_q <= '0;
      dir_q <= '1;
    end else if (wr_en) begin
      unique case (sel)
        SEL_OUT:  out_q <= wdata;
        SEL_INV:  inv_q <= wdata;
        SEL_DIR:  dir_q <= wdata;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] out_q,
  input  logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_do
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_oe[b] <= 1'b0;
        pin_do[b] <= 1'b0;
      end else begin
        pin_oe[b] <= ~dir_q[b];
        pin_do[b] <= dir_q[b] ? 1'b0 : out_q[b];
      end
    end
  end
endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port
  import gpio_regbank_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             in_range,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] pin_view,
  input  logic [WIDTH-1:0] out_q,
  input  logic [WIDTH-1:0] inv_q,
  input  logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid
);
  logic [WIDTH-1:0] sel_data;

  always_comb begin
    sel_data = '0;
    if (in_range) begin
      unique case (sel)
        SEL_PINS: sel_data = pin_view;
        SEL_OUT:  sel_data = out_q;
        SEL_INV:  sel_data = inv_q;
        SEL_DIR:  sel_data = dir_q;
        default:  sel_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel_data;
    end
  end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int CMD_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [CMD_W-1:0] acc_cmd,
  input  logic [WIDTH-1:0] acc_wdata,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_do
);
  localparam int SEL_W = 2;

  logic [WIDTH-1:0] pins_sync;
  logic [WIDTH-1:0] out_q, inv_q, dir_q;
  logic [WIDTH-1:0] pin_view;
  logic             in_range;
  reg_sel_e         sel;

  if (CMD_W > SEL_W) begin : g_range
    assign in_range = (acc_cmd[CMD_W-1:SEL_W] == '0);
  end else begin : g_full
    assign in_range = 1'b1;
  end

  assign sel      = to_sel(acc_cmd[SEL_W-1:0]);
  assign pin_view = pins_sync ^ inv_q;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pins_sync)
  );

  gpio_ctrl_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(acc_valid && acc_write && in_range),
    .sel(sel), .wdata(acc_wdata),
    .out_q(out_q), .inv_q(inv_q), .dir_q(dir_q)
  );

  gpio_pin_drive #(.WIDTH(WIDTH)) u_drive (
    .clk(clk), .rst(rst), .out_q(out_q), .dir_q(dir_q),
    .pin_oe(pin_oe), .pin_do(pin_do)
  );

  gpio_read_port #(.WIDTH(WIDTH)) u_read (
    .clk(clk), .rst(rst),
    .rd_en(acc_valid && !acc_write),
    .in_range(in_range), .sel(sel), .pin_view(pin_view),
    .out_q(out_q), .inv_q(inv_q), .dir_q(dir_q),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/gpio_regbank_checker.sv
module gpio_regbank_checker #(
  parameter int WIDTH = 8,
  parameter int CMD_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic             acc_write,
  input logic [CMD_W-1:0] acc_cmd,
  input logic [WIDTH-1:0] acc_wdata,
  input logic [WIDTH-1:0] rd_data,
  input logic             rd_valid,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] pin_do,
  input logic [WIDTH-1:0] out_q,
  input logic [WIDTH-1:0] inv_q,
  input logic [WIDTH-1:0] dir_q
);
  logic is_read, is_write;
  assign is_read  = acc_valid && !acc_write;
  assign is_write = acc_valid && acc_write;

  // R10
  p_rd_valid_r10: assert property (@(posedge clk) disable iff (rst)
    is_read |=> rd_valid);
  p_no_rd_valid_r10: assert property (@(posedge clk) disable iff (rst)
    !is_read |=> !rd_valid);

  // R4: direction write reaches pin_oe two edges later
  p_dir_to_oe_r4: assert property (@(posedge clk) disable iff (rst)
    (is_write && acc_cmd == 3) |=> ##1 (pin_oe == ~$past(acc_wdata, 2)));

  // R5
  p_input_not_driven_r5: assert property (@(posedge clk) disable iff (rst)
    (pin_do & ~pin_oe) == '0);

  // R3
  p_pins_write_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (is_write && acc_cmd == 0) |=> ($stable(out_q) && $stable(inv_q) && $stable(dir_q)));

  // R9
  p_bad_cmd_read_r9: assert property (@(posedge clk) disable iff (rst)
    (is_read && acc_cmd > 3) |=> (rd_data == '0));
  p_bad_cmd_write_r9: assert property (@(posedge clk) disable iff (rst)
    (is_write && acc_cmd > 3) |=> ($stable(out_q) && $stable(inv_q) && $stable(dir_q)));

  // R8
  p_out_read_r8: assert property (@(posedge clk) disable iff (rst)
    (is_read && acc_cmd == 1) |=> (rd_data == $past(out_q)));
endmodule

bind gpio_regbank gpio_regbank_checker #(.WIDTH(WIDTH), .CMD_W(CMD_W)) u_checker (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_cmd(acc_cmd), .acc_wdata(acc_wdata), .rd_data(rd_data),
  .rd_valid(rd_valid), .pin_oe(pin_oe), .pin_do(pin_do),
  .out_q(out_q), .inv_q(inv_q), .dir_q(dir_q)
);

// File: tb/tb_gpio_regbank.sv
module tb_gpio_regbank;
  localparam int W = 8;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_valid = 1'b0;
  logic          acc_write = 1'b0;
  logic [CW-1:0] acc_cmd = '0;
  logic [W-1:0]  acc_wdata = '0;
  logic [W-1:0]  rd_data, pin_in, pin_oe, pin_do;
  logic          rd_valid;

  logic [W-1:0]  ext_en = '0;
  logic [W-1:0]  ext_val = '0;

  // bench model of register state
  logic [W-1:0]  m_out = 8'hFF, m_inv = 8'h00, m_dir = 8'hFF;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #4 clk = ~clk;

  gpio_regbank #(.WIDTH(W), .CMD_W(CW)) dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_cmd(acc_cmd), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .pin_in(pin_in), .pin_oe(pin_oe), .pin_do(pin_do)
  );

  // pad model: own driver, else external driver, else pull-up
  for (genvar b = 0; b < W; b++) begin : g_pad
    assign pin_in[b] = pin_oe[b] ? pin_do[b] : (ext_en[b] ? ext_val[b] : 1'b1);
  end

  function automatic logic [W-1:0] model_pad();
    logic [W-1:0] p;
    for (int b = 0; b < W; b++)
      p[b] = !m_dir[b] ? m_out[b] : (ext_en[b] ? ext_val[b] : 1'b1);
    return p;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [CW-1:0] cmd, input logic [W-1:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_cmd = cmd; acc_wdata = d;
    if (cmd == 1) m_out = d;
    else if (cmd == 2) m_inv = d;
    else if (cmd == 3) m_dir = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd(input logic [CW-1:0] cmd, input logic [W-1:0] exp, input string req);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_cmd = cmd;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic check_pins(input string req);
    check({req, " pin_oe"}, pin_oe, ~m_dir);
    check({req, " pin_do"}, pin_do, m_out & ~m_dir);
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R10: unexpected rd_valid, actual %02h expected none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle(3);
    // R1 reset state
    check_pins("R1");
    rd(1, 8'hFF, "R1 out");
    rd(2, 8'h00, "R1 inv");
    rd(3, 8'hFF, "R1 dir");
    rd(0, 8'hFF, "R1 pullups");
    idle(1);
    check("R10 idle", {7'd0, rd_valid}, 8'h00);

    // R2 writes and readback
    wr(1, 8'h5A);
    check("R10 after write", {7'd0, rd_valid}, 8'h00);
    wr(2, 8'h0F);
    wr(3, 8'hC3);
    rd(1, 8'h5A, "R2 out");
    rd(2, 8'h0F, "R2 inv");
    rd(3, 8'hC3, "R2 dir");

    // R4/R5 pin drive
    ext_en = 8'hFF; ext_val = 8'h81;
    idle(4);
    check_pins("R4");
    check("R5 input pins undriven", pin_do & m_dir, 8'h00);
    // R7/R6 pin view with own-driven pins
    rd(0, model_pad() ^ m_inv, "R7 mixed");
    wr(2, 8'hF0);
    rd(0, model_pad() ^ 8'hF0, "R6 inv F0");
    wr(2, 8'h00);
    rd(0, model_pad(), "R6 inv 00");

    // R3 command 0 write ignored
    wr(0, 8'h00);
    idle(3);
    check_pins("R3");
    rd(1, m_out, "R3 out");
    rd(2, m_inv, "R3 inv");
    rd(3, m_dir, "R3 dir");
    rd(0, model_pad() ^ m_inv, "R3 pins");

    // R9 out-of-range commands
    wr(5, 8'h00);
    wr(7, 8'h00);
    idle(3);
    check_pins("R9");
    rd(5, 8'h00, "R9 read 5");
    rd(7, 8'h00, "R9 read 7");
    rd(1, m_out, "R9 out");
    rd(3, m_dir, "R9 dir");

    // R8/R5 all inputs, store FF, pins externally low
    wr(3, 8'hFF);
    wr(1, 8'hFF);
    ext_val = 8'h00;
    idle(4);
    check("R5 oe", pin_oe, 8'h00);
    check("R5 do", pin_do, 8'h00);
    rd(1, 8'hFF, "R8 stored flop");
    rd(0, 8'h00, "R8 pin view");

    // R11 synchronizer latency
    idle(2);
    @(negedge clk);
    ext_val = 8'h3C;
    acc_valid = 1; acc_write = 0; acc_cmd = 0;
    exp_q.push_back(8'h00); tag_q.push_back("R11 first edge old");
    @(negedge clk);
    acc_valid = 0;
    rd(0, 8'h3C, "R11 two edges new");

    // R6 inversion on pure inputs
    wr(2, 8'h0F);
    rd(0, 8'h3C ^ 8'h0F, "R6 inputs inverted");
    idle(4);
    if (exp_q.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL R10: missing reads, actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule